// File: doc/BRIEF.md
# Standard Parallel Port Register File

This block is the byte-wide register file of a PC-style standard parallel port. A host bus reaches it with a three-bit offset and separate read and write strobes. It holds five things: a data latch that drives the output data pins, a control register that drives the control pins, a read-only status register assembled from the synchronized status pins, and two plain storage bytes for the enhanced-port address and data slots.

An interrupt output is raised when the acknowledge pin falls while the interrupt enable in control is set. It stays high until software reads the status register. When the direction bit in control is set, a data read returns the live data input pins and loads them into the latch.

Read data is combinational from the offset while the read strobe is high. Read side effects (clearing the interrupt, loading the latch) and all writes take effect at the rising clock edge that ends the access. Read and write strobes are mutually exclusive; when both are high, the write is performed and the read has no side effects.

Top module: `spp_regs`

## Requirements
- R1: After reset the data latch, `pd_out`, both storage bytes and `irq_o` are 0, and the control register and `ctl_o` are 0xC0.
- R2: A write to offset 0 stores the byte in the data latch and shows it on `pd_out` after the clock edge. While control bit 5 is 0, a read of offset 0 returns the latch.
- R3: A write to offset 2 stores the written byte with bits 7 and 6 forced to 1. The stored value appears on `ctl_o` and reads back at offset 2.
- R4: While control bit 5 is 1, a read of offset 0 returns `pd_in`, and at the clock edge the latch (and `pd_out`) takes that byte.
- R5: A read of offset 1 returns {`sts_i[4:0]` synchronized by two flops, `irq_o`, 1, 0}. From MSB down, `sts_i` is busy, ack, paper-out, select-in, error, so ack is `sts_i[3]` and appears in status bit 6.
- R6: A falling edge of the synchronized ack input sets `irq_o` when control bit 4 is 1. With bit 4 at 0, or on a rising edge, `irq_o` is not set.
- R7: A read of offset 1 clears `irq_o` at its clock edge, unless an enabled ack fall occurs in the same cycle.
- R8: Offsets 3 and 4 are independent read/write storage bytes.
- R9: Writes to offsets 1, 5, 6 and 7 change no register and no output.
- R10: Reads of offsets 5, 6 and 7 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pd_in | input | 8 | Data input pins |
| pd_out | output | 8 | Data output pins (latch) |
| sts_i | input | 5 | Status pins: busy, ack, paper-out, select-in, error |
| ctl_o | output | 8 | Control register onto pins |
| irq_o | output | 1 | Interrupt, level |

## Verification
The bench sweeps all 256 values through the data latch, the control register and both storage bytes, and all 32 status pin patterns.

- A design that forgot to force the reserved control bits would read back values below 0xC0.
- A design that mirrored `pd_in` only on read, without loading the latch, shows a stale `pd_out` and a stale readback after the direction bit is cleared.
- The interrupt tests drive an ack fall with the enable off, a rising ack with the enable on, and an enabled fall followed by a status read. These catch an ungated interrupt, an edge detector of the wrong polarity and a missing read-to-clear.
- Writes to the dead offsets are followed by a readback of every register and a look at all outputs, so an address decode that aliases onto a live register is exposed.

// File: rtl/spp_regs.sv
module spp_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  input  logic [4:0] sts_i,
  output logic [7:0] ctl_o,
  output logic       irq_o
);
  localparam logic [7:0] CTL_RSV = 8'hC0;

  logic [7:0] data_q, ctl_q, epa_q, epd_q;
  logic [4:0] s1_q, s2_q;
  logic       ack_d, irq_q;

  wire rd_only  = rd_en & ~wr_en;
  wire rd_sts   = rd_only & (addr == 3'd1);
  wire rd_bidir = rd_only & (addr == 3'd0) & ctl_q[5];
  wire ack_fall = ack_d & ~s2_q[3];
  wire [7:0] status = {s2_q, irq_q, 1'b1, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      ack_d <= 1'b0;
    end else begin
      s1_q  <= sts_i;
      s2_q  <= s1_q;
      ack_d <= s2_q[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= CTL_RSV;
      epa_q  <= '0;
      epd_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: data_q <= wdata;
        3'd2: ctl_q  <= wdata | CTL_RSV;
        3'd3: epa_q  <= wdata;
        3'd4: epd_q  <= wdata;
        default: ;
      endcase
    end else if (rd_bidir) begin
      data_q <= pd_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  irq_q <= 1'b0;
    else if (ack_fall && ctl_q[4]) irq_q <= 1'b1;
    else if (rd_sts)             irq_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = ctl_q[5] ? pd_in : data_q;
      3'd1:    rdata = status;
      3'd2:    rdata = ctl_q;
      3'd3:    rdata = epa_q;
      3'd4:    rdata = epd_q;
      default: rdata = 8'hFF;
    endcase
  end

  assign pd_out = data_q;
  assign ctl_o  = ctl_q;
  assign irq_o  = irq_q;

  p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd0 |=> pd_out == $past(wdata));
  p_ctl_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd2 |=> ctl_o == ($past(wdata) | 8'hC0));
  p_bidir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only && addr == 3'd0 && ctl_o[5] |=> pd_out == $past(pd_in));
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o && !ctl_o[4] |=> !irq_o);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts && !ack_fall |=> !irq_o);
  p_dead_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == 3'd1 || addr >= 3'd5) |=>
      $stable(pd_out) && $stable(ctl_o) && $stable(epa_q) && $stable(epd_q));
  p_dead_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr >= 3'd5 |-> rdata == 8'hFF);
endmodule

// File: tb/spp_regs_tb.sv
module spp_regs_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, pd_in = 0, pd_out, ctl_o;
  logic [4:0] sts_i = 0;
  logic irq_o;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  spp_regs u_dut (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata,
                  .pd_in, .pd_out, .sts_i, .ctl_o, .irq_o);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #2 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 ctl_o", ctl_o, 8'hC0);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    rd(3'd0, rv); chk("R1 data", rv, 8'h00);
    rd(3'd3, rv); chk("R1 epp addr", rv, 8'h00);
    rd(3'd4, rv); chk("R1 epp data", rv, 8'h00);

    // R2 data latch sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      chk("R2 pd_out", pd_out, 8'(v));
      rd(3'd0, rv); chk("R2 readback", rv, 8'(v));
    end

    // R3 control sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      chk("R3 ctl_o", ctl_o, 8'(v) | 8'hC0);
      rd(3'd2, rv); chk("R3 readback", rv, 8'(v) | 8'hC0);
    end
    wr(3'd2, 8'h00);

    // R8 storage bytes
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, 8'(v)); wr(3'd4, 8'(255 - v));
      rd(3'd3, rv); chk("R8 epp addr", rv, 8'(v));
      rd(3'd4, rv); chk("R8 epp data", rv, 8'(255 - v));
    end

    // R4 bidirectional read
    wr(3'd0, 8'hA5);
    pd_in = 8'h3C;
    rd(3'd0, rv); chk("R4 latch when bit5=0", rv, 8'hA5);
    wr(3'd2, 8'h20);
    rd(3'd0, rv); chk("R4 live pins", rv, 8'h3C);
    chk("R4 latch loaded", pd_out, 8'h3C);
    pd_in = 8'h81;
    wr(3'd2, 8'h00);
    rd(3'd0, rv); chk("R4 loaded byte kept", rv, 8'h3C);

    // R5 status sweep, interrupt disabled
    for (int p = 0; p < 32; p++) begin
      @(negedge clk); sts_i = 5'(p);
      idle(3);
      rd(3'd1, rv); chk("R5 status", rv, {5'(p), 3'b010});
    end

    // R6 disabled fall, enabled rise, enabled fall
    @(negedge clk); sts_i = 5'b01000; idle(4);
    sts_i = 5'b00000; idle(4);
    chk("R6 no irq when disabled", {7'd0, irq_o}, 8'h00);
    wr(3'd2, 8'h10);
    @(negedge clk); sts_i = 5'b01000; idle(4);
    chk("R6 no irq on rise", {7'd0, irq_o}, 8'h00);
    sts_i = 5'b00000; idle(4);
    chk("R6 irq on fall", {7'd0, irq_o}, 8'h01);
    idle(5);
    chk("R6 irq held", {7'd0, irq_o}, 8'h01);

    // R7 read to clear
    rd(3'd1, rv); chk("R7 status irq bit", rv, 8'h06);
    chk("R7 irq cleared", {7'd0, irq_o}, 8'h00);
    rd(3'd1, rv); chk("R7 status after clear", rv, 8'h02);

    // R9 dead writes
    wr(3'd0, 8'h5A); wr(3'd2, 8'h0C); wr(3'd3, 8'h11); wr(3'd4, 8'h22);
    wr(3'd1, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    chk("R9 pd_out", pd_out, 8'h5A);
    chk("R9 ctl_o", ctl_o, 8'hCC);
    chk("R9 irq", {7'd0, irq_o}, 8'h00);
    rd(3'd0, rv); chk("R9 data", rv, 8'h5A);
    rd(3'd2, rv); chk("R9 control", rv, 8'hCC);
    rd(3'd3, rv); chk("R9 epp addr", rv, 8'h11);
    rd(3'd4, rv); chk("R9 epp data", rv, 8'h22);
    rd(3'd1, rv); chk("R9 status", rv, 8'h02);

    // R10 dead reads
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), rv); chk("R10 unused offset", rv, 8'hFF);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule